// File: doc/BRIEF.md
# DVMA Page-Table Translation Walker

This block turns device transfer requests, expressed as device virtual addresses, into physical memory accesses with 36-bit addresses. It has no translation cache. For every 4 KB page that a transfer touches, the walker reads one 32-bit page-table entry through a memory port and checks the entry's permission bits. If the checks pass, it issues one physical access covering the part of the transfer that lies inside that page.

The register block supplies two values: the page-table base and the start of the device address window. The device offset is the device address minus the window start. That offset selects the entry, and the entry supplies the physical page number.

A missing mapping, or a write to a read-only page, stops the transfer. The walker then hands a fault record (status word and page-aligned device address) to the register block, which raises its interrupt. The request completes with an error.

Top module: `dvma_xlate_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle, and it is high after reset. Each accepted request ends with exactly one single-cycle `done_valid` pulse. `req_ready` is low in the cycle after acceptance.
- R2: The entry fetch address is `cfg_pt_base * 16 + 4 * ((req_addr - cfg_win_start) >> 12)`, computed in 36 bits. The walker issues exactly one fetch per page touched, in ascending page order.
- R3: The physical address of an access is the entry's bits 31:8 as PA[35:12], concatenated with the low 12 bits of the current device address.
- R4: A transfer is cut at 4 KB boundaries. Each access length is the smaller of the remaining bytes and `4096 - addr[11:0]`. Accesses are issued in address order, and `acc_write` repeats the request's direction.
- R5: An entry whose bit 1 (valid) is clear causes a fault, and no access is issued for that page.
- R6: A write to a page whose entry bit 2 (writeable) is clear causes a fault. Reads ignore bit 2, and entry bits 7 and 0 have no effect on any outcome.
- R7: The fault status word is 0xC0800000 for a write and 0xC0840000 for a read (bit 18 marks a read).
- R8: The fault address is the device address of the faulting page with bits 11:0 cleared. `flt_valid` pulses only in the same cycle as a `done_valid` that carries `done_err`.
- R9: A fault ends the transfer. No further fetch or access follows, and `done_err` is 1. A transfer without a fault ends with `done_err` 0.
- R10: A zero-length request completes without any fetch or access and without error.
- R11: `mem_req_valid`/`mem_req_addr` and `acc_valid`/`acc_addr` hold steady until accepted. No access is issued before the entry read has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_addr | input | 32 | Device start address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_write | input | 1 | 1 = write to memory, 0 = read |
| done_valid | output | 1 | Transfer completion pulse |
| done_err | output | 1 | Transfer ended on a fault |
| cfg_pt_base | input | 32 | Page-table base (shifted left by 4) |
| cfg_win_start | input | 32 | Device window start address |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Entry read accepted |
| mem_req_addr | output | 36 | Entry read address |
| mem_rsp_valid | input | 1 | Entry read data present |
| mem_rsp_data | input | 32 | Entry read data |
| acc_valid | output | 1 | Physical access request |
| acc_ready | input | 1 | Physical access accepted |
| acc_addr | output | 36 | Physical start address |
| acc_len | output | LEN_W | Access length in bytes |
| acc_write | output | 1 | Access direction |
| flt_valid | output | 1 | Fault record strobe (interrupt raise) |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Page-aligned faulting device address |

## Verification
The assertions rely on three properties of the environment. First, the page-table base and window start stay fixed while a transfer is in flight. Second, the memory returns exactly one response for each accepted entry read, and only while the walker waits for it. Third, `acc_ready` may be withheld for any number of cycles. The stimulus changes configuration only between transfers, and its memory model answers each fetch once after a random delay of one to three cycles. The ready lines are driven randomly, so the hold-until-accepted checks are exercised under back-pressure.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

  localparam int PAGE_SHIFT = 12;
  localparam int PA_W       = 36;
  localparam int PTE_VALID  = 1;
  localparam int PTE_WRITE  = 2;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_FETCH,
    WS_WAIT,
    WS_ISSUE,
    WS_DONE
  } walk_state_e;

  // Entry location: base scaled by 16 plus four bytes per page of offset.
  function automatic logic [PA_W-1:0] entry_addr(input logic [31:0] base,
                                                 input logic [31:0] dva,
                                                 input logic [31:0] win);
    logic [31:0] off;
    off = dva - win;
    return {base, 4'b0000} + {14'b0, off[31:PAGE_SHIFT], 2'b00};
  endfunction

  // Physical address: page number from entry bits 31:8, page offset from dva.
  function automatic logic [PA_W-1:0] phys_addr(input logic [31:0] pte,
                                                input logic [31:0] dva);
    return {pte[31:8], dva[PAGE_SHIFT-1:0]};
  endfunction

  function automatic logic entry_faults(input logic [31:0] pte,
                                        input logic is_write);
    return !pte[PTE_VALID] || (is_write && !pte[PTE_WRITE]);
  endfunction

  function automatic logic [31:0] fault_word(input logic is_write);
    return 32'hC080_0000 | (is_write ? 32'h0 : 32'h0004_0000);
  endfunction

endpackage

// File: rtl/dvma_cursor.sv
module dvma_cursor #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      load_addr,
  input  logic [LEN_W-1:0] load_len,
  input  logic             adv,
  output logic [31:0]      cur_addr,
  output logic [LEN_W-1:0] chunk,
  output logic             last
);
  import dvma_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

  logic [31:0]       cur_q;
  logic [LEN_W-1:0]  rem_q;
  logic [PAGE_SHIFT:0] room;
  logic [LEN_W-1:0]  room_ext;

  assign room     = (PAGE_SHIFT+1)'(PAGE_BYTES) - {1'b0, cur_q[PAGE_SHIFT-1:0]};
  assign room_ext = LEN_W'(room);
  assign chunk    = (rem_q < room_ext) ? rem_q : room_ext;
  assign last     = (rem_q == chunk);
  assign cur_addr = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      rem_q <= '0;
    end else if (load) begin
      cur_q <= load_addr;
      rem_q <= load_len;
    end else if (adv) begin
      cur_q <= cur_q + 32'(chunk);
      rem_q <= rem_q - chunk;
    end
  end

  // R4: a chunk never leaves its page and never exceeds what remains
  AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (chunk <= rem_q) && (chunk <= room_ext) && (chunk != '0)); // R4

endmodule

// File: rtl/dvma_pte_judge.sv
module dvma_pte_judge (
  input  logic [31:0] pte,
  input  logic        is_write,
  output logic        bad,
  output logic [31:0] status
);
  import dvma_pkg::*;

  assign bad    = entry_faults(pte, is_write);
  assign status = fault_word(is_write);

  // R7: fault word always carries the error, late-error and reserved bits
  AST_STATUS_BITS: assert final (status[31] && status[30] && status[23]); // R7

endmodule

// File: rtl/dvma_xlate_walker.sv
module dvma_xlate_walker #(
  parameter int LEN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [31:0]            req_addr,
  input  logic [LEN_W-1:0]       req_len,
  input  logic                   req_write,
  output logic                   done_valid,
  output logic                   done_err,
  input  logic [31:0]            cfg_pt_base,
  input  logic [31:0]            cfg_win_start,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [35:0]            mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [31:0]            mem_rsp_data,
  output logic                   acc_valid,
  input  logic                   acc_ready,
  output logic [35:0]            acc_addr,
  output logic [LEN_W-1:0]       acc_len,
  output logic                   acc_write,
  output logic                   flt_valid,
  output logic [31:0]            flt_status,
  output logic [31:0]            flt_addr
);
  import dvma_pkg::*;

  walk_state_e st_q, st_d;
  logic        wr_q, err_q;
  logic [35:0] pa_q;
  logic [31:0] flt_status_q, flt_addr_q;

  logic [31:0]      cur_addr;
  logic [LEN_W-1:0] chunk;
  logic             last;
  logic             pte_bad;
  logic [31:0]      pte_status;

  // named internal events
  logic req_fire, fetch_fire, rsp_hit, issue_fire, zero_req;
  assign req_fire   = (st_q == WS_IDLE) && req_valid;
  assign zero_req   = req_fire && (req_len == '0);
  assign fetch_fire = (st_q == WS_FETCH) && mem_req_ready;
  assign rsp_hit    = (st_q == WS_WAIT) && mem_rsp_valid;
  assign issue_fire = (st_q == WS_ISSUE) && acc_ready;

  dvma_cursor #(.LEN_W(LEN_W)) cursor_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (req_fire),
    .load_addr(req_addr),
    .load_len (req_len),
    .adv      (issue_fire),
    .cur_addr (cur_addr),
    .chunk    (chunk),
    .last     (last)
  );

  dvma_pte_judge judge_i (
    .pte     (mem_rsp_data),
    .is_write(wr_q),
    .bad     (pte_bad),
    .status  (pte_status)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WS_IDLE:  if (req_valid) st_d = zero_req ? WS_DONE : WS_FETCH;
      WS_FETCH: if (mem_req_ready) st_d = WS_WAIT;
      WS_WAIT:  if (mem_rsp_valid) st_d = pte_bad ? WS_DONE : WS_ISSUE;
      WS_ISSUE: if (acc_ready) st_d = last ? WS_DONE : WS_FETCH;
      WS_DONE:  st_d = WS_IDLE;
      default:  st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= WS_IDLE;
      wr_q         <= 1'b0;
      err_q        <= 1'b0;
      pa_q         <= '0;
      flt_status_q <= '0;
      flt_addr_q   <= '0;
    end else begin
      st_q <= st_d;
      if (req_fire) begin
        wr_q  <= req_write;
        err_q <= 1'b0;
      end
      if (rsp_hit) begin
        if (pte_bad) begin
          err_q        <= 1'b1;
          flt_status_q <= pte_status;
          flt_addr_q   <= {cur_addr[31:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        end else begin
          pa_q <= phys_addr(mem_rsp_data, cur_addr);
        end
      end
    end
  end

  assign req_ready     = (st_q == WS_IDLE);
  assign mem_req_valid = (st_q == WS_FETCH);
  assign mem_req_addr  = entry_addr(cfg_pt_base, cur_addr, cfg_win_start);
  assign acc_valid     = (st_q == WS_ISSUE);
  assign acc_addr      = pa_q;
  assign acc_len       = chunk;
  assign acc_write     = wr_q;
  assign done_valid    = (st_q == WS_DONE);
  assign done_err      = err_q;
  assign flt_valid     = (st_q == WS_DONE) && err_q;
  assign flt_status    = flt_status_q;
  assign flt_addr      = flt_addr_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready); // R1
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_addr) && $stable(acc_len)); // R11
  AST_ACC_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_valid) |-> $past(mem_rsp_valid)); // R11
  AST_ACC_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (32'(acc_addr[11:0]) + 32'(acc_len)) <= 32'd4096); // R4
  AST_FLT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> done_valid && done_err && (flt_addr[11:0] == 12'h000)); // R8
  AST_FLT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> (flt_status[31:30] == 2'b11) && flt_status[23]); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && mem_req_valid) && !(acc_valid && done_valid)); // R9

endmodule

// File: tb/dvma_xlate_walker_tb.sv
module dvma_xlate_walker_tb_top;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_ready, done_valid, done_err;
  logic [31:0]      cfg_pt_base = '0, cfg_win_start = '0;
  logic             mem_req_valid, mem_req_ready = 1'b0;
  logic [35:0]      mem_req_addr;
  logic             mem_rsp_valid = 1'b0;
  logic [31:0]      mem_rsp_data = '0;
  logic             acc_valid, acc_ready = 1'b0, acc_write;
  logic [35:0]      acc_addr;
  logic [LEN_W-1:0] acc_len;
  logic             flt_valid;
  logic [31:0]      flt_status, flt_addr;

  dvma_xlate_walker #(.LEN_W(LEN_W)) dut_i (.*);

  int n_chk = 0, n_err = 0;
  int pte_mode = 0;
  logic [35:0] bad_ea = '0;

  logic [35:0] q_ea[$], q_pa[$];
  int          q_len[$];
  logic        x_fault, x_wr, done_seen, done_err_seen;
  logic [31:0] x_faddr;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // entry content model; bits 7 and 0 vary freely (R6)
  function automatic logic [31:0] pte_of(input logic [35:0] ea);
    logic [31:0] h;
    logic v, w;
    h = (ea[31:0] * 32'h9E37_79B1) ^ (ea[31:0] >> 9) ^ {ea[35:32], 28'h0};
    v = 1'b1; w = 1'b1;
    case (pte_mode)
      1: begin v = (h[3:1] != 3'b0); w = (h[5:4] != 2'b0); end
      2: v = 1'b0;
      3: w = 1'b0;
      4: v = (ea != bad_ea);
      default: ;
    endcase
    return {h[31:8], h[7], 4'b0000, w, v, h[0]};
  endfunction

  function automatic logic [35:0] exp_ea_of(input logic [31:0] dva);
    logic [31:0] idx;
    idx = ((dva - cfg_win_start) >> 10) & ~32'd3;
    return (36'(cfg_pt_base) << 4) + 36'(idx);
  endfunction

  // build expected fetch/access sequence from the requirements
  task automatic plan_xfer(input logic [31:0] a, input int len, input logic wr);
    logic [31:0] cur;
    int rem, room, c;
    logic [31:0] p;
    cur = a; rem = len; x_fault = 1'b0; x_wr = wr;
    q_ea.delete(); q_pa.delete(); q_len.delete();
    while (rem > 0) begin
      q_ea.push_back(exp_ea_of(cur));
      p = pte_of(exp_ea_of(cur));
      if (!p[1] || (wr && !p[2])) begin
        x_fault = 1'b1;
        x_faddr = cur & 32'hFFFF_F000;
        break;
      end
      room = 4096 - int'(cur % 4096);
      c = (rem < room) ? rem : room;
      q_pa.push_back({p[31:8], 12'h000} + 36'(cur % 4096));
      q_len.push_back(c);
      cur += 32'(c); rem -= c;
    end
  endtask

  // memory model and monitors; readies set first, then handshakes observed (R11)
  logic        pend = 1'b0;
  int          lat = 0;
  logic [35:0] pea = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = pte_of(pea);
          pend = 1'b0;
        end else lat--;
      end
      mem_req_ready = ($urandom_range(0, 3) != 0);
      acc_ready     = ($urandom_range(0, 3) != 0);
      if (mem_req_valid && mem_req_ready) begin
        if (q_ea.size() == 0) chk(1'b0, "R9 unexpected fetch", mem_req_addr, 0);
        else begin
          logic [35:0] e;
          e = q_ea.pop_front();
          chk(mem_req_addr == e, "R2 entry address", mem_req_addr, e);
        end
        pend = 1'b1; lat = $urandom_range(0, 2); pea = mem_req_addr;
      end
      if (acc_valid && acc_ready) begin
        if (q_pa.size() == 0) chk(1'b0, "R5/R9 unexpected access", acc_addr, 0);
        else begin
          logic [35:0] e;
          int l;
          e = q_pa.pop_front(); l = q_len.pop_front();
          chk(acc_addr == e, "R3 physical address", acc_addr, e);
          chk(int'(acc_len) == l, "R4 chunk length", acc_len, l);
          chk(acc_write == x_wr, "R4 access direction", acc_write, x_wr);
        end
      end
      if (flt_valid && !done_valid) chk(1'b0, "R8 fault strobe without done", flt_valid, 0);
      if (done_valid) begin
        done_seen = 1'b1; done_err_seen = done_err;
        chk(done_err == x_fault, "R9 done error flag", done_err, x_fault);
        chk(flt_valid == x_fault, "R8 fault strobe", flt_valid, x_fault);
        if (x_fault) begin
          logic [31:0] sw;
          sw = x_wr ? 32'hC080_0000 : 32'hC084_0000;
          chk(flt_status == sw, "R7 fault status", flt_status, sw);
          chk(flt_addr == x_faddr, "R8 fault address", flt_addr, x_faddr);
        end
      end
    end
  end

  task automatic run_xfer(input logic [31:0] a, input int len, input logic wr);
    int t;
    plan_xfer(a, len, wr);
    done_seen = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_len = LEN_W'(len); req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
    t = 0;
    while (!done_seen && t < 5000) begin @(negedge clk); t++; end
    if (!done_seen) chk(1'b0, "R1 completion timeout", 0, 1);
    chk(q_ea.size() == 0 && q_pa.size() == 0, "R9 sequence complete",
        q_ea.size() + q_pa.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    done_seen = 1'b0; x_fault = 1'b0; x_wr = 1'b0; x_faddr = '0; done_err_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !acc_valid && !done_valid && !flt_valid,
        "R1 reset state", {req_ready, mem_req_valid, acc_valid, done_valid}, 4'b1000);

    cfg_pt_base = 32'h0123_4560; cfg_win_start = 32'hFF00_0000;
    pte_mode = 0;
    run_xfer(32'hFF00_2100, 0, 1'b1);          // R10 zero length
    run_xfer(32'hFF00_0000, 4096, 1'b0);       // R4 exact page
    run_xfer(32'hFF00_1FF0, 40, 1'b1);         // R4 crosses boundary
    run_xfer(32'hFF00_3010, 9000, 1'b0);       // R4 three pages
    pte_mode = 2;
    run_xfer(32'hFF00_5123, 100, 1'b0);        // R5 invalid entry, read
    run_xfer(32'hFF00_6000, 100, 1'b1);        // R5 invalid entry, write
    pte_mode = 3;
    run_xfer(32'hFF00_7800, 3000, 1'b0);       // R6 read of read-only page
    run_xfer(32'hFF00_7800, 3000, 1'b1);       // R6 write to read-only page
    pte_mode = 4;
    bad_ea = exp_ea_of(32'hFF00_9000);
    run_xfer(32'hFF00_8F00, 9000, 1'b1);       // R9 fault on second page
    chk(done_err_seen == 1'b1, "R9 mid-transfer fault", done_err_seen, 1);

    for (int i = 0; i < 200; i++) begin
      cfg_pt_base   = $urandom();
      cfg_win_start = $urandom() & 32'hFFFF_F000;
      pte_mode = (i % 4 == 0) ? 0 : 1;
      run_xfer(cfg_win_start + ($urandom_range(0, 255) << 12) + $urandom_range(0, 4095),
               (i % 25 == 0) ? 0 : $urandom_range(1, 12000), 1'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule